// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block is a serial peripheral slave that takes 16-bit command words from a host over a select line, a serial clock and a data input. It accepts both the clock-idles-low and the clock-idles-high variants in which data is captured on the rising serial clock edge and launched on the falling edge. It learns the variant from the level the serial clock rests at when select goes low. All three serial inputs are brought into the system clock domain by synchronisers. The system clock must run at least four times faster than the serial clock.

During each select-low window the block counts rising serial clock edges and shifts data in MSB first. When select rises it hands the last 16 received bits to a parallel output register and pulses a one-cycle strobe. It does so only if the edge count is a non-zero multiple of 16 and the serial clock is back at its idle level. Any other window is dropped without effect, so a short select pulse puts the interface back into a known state. The serial output carries the shift register's top bit, so that devices can be daisy-chained. Its enable is low while select is high, so the pad can be tri-stated.

Top module: `spi_cmd_port`

## Requirements
- R1: DIN is captured on each rising SCLK edge while cs_n is low and shifted in MSB first. After a valid frame, cmd_word holds the 16 captured bits with the first captured bit at bit 15.
- R2: Both the idle-low clock variant (SCLK low when cs_n falls) and the idle-high variant (SCLK high when cs_n falls) deliver the same word. The idle level is latched at the falling edge of cs_n.
- R3: cmd_word is written only when cs_n rises after a rising-edge count that is a non-zero multiple of 16. After 0, 15 or 17 edges, cmd_word keeps its value and cmd_valid stays low.
- R4: When the count is 32 or any larger multiple of 16, the last 16 bits captured are committed.
- R5: A frame is committed only if SCLK is at the idle level latched under R2 when cs_n rises. Otherwise it is discarded as under R3.
- R6: Each commit raises cmd_valid for exactly one clk cycle, in the same cycle that cmd_word takes its new value. Between commits, cmd_word does not change.
- R7: dout changes only after falling SCLK edges. Just before rising edge k of a frame it shows the bit captured at rising edge k-16, and it shows 0 for k from 1 to 16.
- R8: dout_oe is 1 while cs_n is 0 and 0 while cs_n is 1. A pad driver tri-states DOUT when dout_oe is 0.
- R9: After reset, cmd_word is 0, cmd_valid is 0 and dout is 0.
- R10: The edge count and the shift register restart at each falling edge of cs_n. A frame after a discarded window is judged and captured on its own edges only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output for daisy-chaining |
| dout_oe | output | 1 | Output enable for the DOUT pad driver |
| cmd_word | output | 16 | Last committed command word |
| cmd_valid | output | 1 | One-cycle strobe marking a commit |

## Verification
The embedded properties check, on every cycle, the behaviour that follows locally from the synchronised edges:
- the counter restarts after a select fall and steps by one on each captured rising edge;
- the shift register is frozen while deselected;
- the commit strobe lasts a single cycle and only ever follows a select rise;
- the output word never moves without the strobe.

Only the bench scenarios can show the frame-level outcomes, because they depend on whole transactions:
- which edge counts and idle levels lead to a commit (R2 to R5, R10);
- that the committed word is the last 16 bits in MSB-first order;
- that dout reproduces the input 16 edges later in both clock variants.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // Synchronised view of the serial pins, with edges detected in the clk domain.
  typedef struct packed {
    logic cs_low;
    logic cs_fall;
    logic cs_rise;
    logic sclk_lvl;
    logic sclk_rise;
    logic sclk_fall;
    logic din;
  } ser_evt_t;
endpackage

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     sclk,
  input  logic     din,
  output ser_evt_t evt
);
  localparam int NPINS = 3;
  // Reset levels per pin: index 2 = cs_n (idle high), 1 = sclk, 0 = din.
  localparam logic [NPINS-1:0] PIN_RST = 3'b100;

  logic [NPINS-1:0]       raw;
  logic [SYNC_STAGES-1:0] stage [NPINS];
  logic [NPINS-1:0]       synced;
  logic                   cs_d, sclk_d;

  assign raw = {cs_n, sclk, din};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= {SYNC_STAGES{PIN_RST[g]}};
      else        stage[g] <= {stage[g][SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = stage[g][SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= synced[2];
      sclk_d <= synced[1];
    end
  end

  always_comb begin
    evt.cs_low    = ~synced[2];
    evt.cs_fall   = cs_d & ~synced[2];
    evt.cs_rise   = ~cs_d & synced[2];
    evt.sclk_lvl  = synced[1];
    evt.sclk_rise = ~sclk_d & synced[1];
    evt.sclk_fall = sclk_d & ~synced[1];
    evt.din       = synced[0];
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ser_evt_t          evt,
  output logic [WORD_W-1:0] shift_word,
  output logic              frame_ok,
  output logic              dout
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              seen_q, seen_d;
  logic              idle_q, idle_d;
  logic              dout_q, dout_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;
    idle_d = idle_q;
    dout_d = dout_q;
    if (evt.cs_fall) begin
      sr_d   = '0;
      cnt_d  = '0;
      seen_d = 1'b0;
      dout_d = 1'b0;
      idle_d = evt.sclk_lvl;
    end else if (evt.cs_low) begin
      if (evt.sclk_rise) begin
        sr_d   = {sr_q[WORD_W-2:0], evt.din};
        cnt_d  = cnt_q + 1'b1;
        seen_d = 1'b1;
      end
      if (evt.sclk_fall) dout_d = sr_q[WORD_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      idle_q <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      idle_q <= idle_d;
      dout_q <= dout_d;
    end
  end

  assign shift_word = sr_q;
  assign dout       = dout_q;
  // Whole frames only, and the clock must rest at the latched idle level.
  assign frame_ok   = seen_q && (cnt_q == '0) && (evt.sclk_lvl == idle_q);

  // R10: a select fall restarts the count
  assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_fall |=> (cnt_q == '0) && !seen_q);

  // R3: each captured rising edge advances the count by one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.cs_low && !evt.cs_fall && evt.sclk_rise) |=>
      (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && seen_q);

  // R3: nothing is captured while deselected
  assert_hold_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.cs_low && !evt.cs_fall) |=> $stable(sr_q));
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_valid
);
  ser_evt_t          evt;
  logic [WORD_W-1:0] shift_word;
  logic              frame_ok;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  spi_cmd_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .din   (din),
    .evt   (evt)
  );

  spi_cmd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .shift_word (shift_word),
    .frame_ok   (frame_ok),
    .dout       (dout)
  );

  always_comb begin
    valid_d = evt.cs_rise && frame_ok;
    word_d  = valid_d ? shift_word : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign cmd_word  = word_q;
  assign cmd_valid = valid_q;
  // The pad enable follows the select pin directly, with no synchroniser delay.
  assign dout_oe   = ~cs_n;

  // R6: the strobe lasts one cycle
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R6: the word only moves together with the strobe
  assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_word));

  // R3: a commit only follows a select rise
  assert_commit_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(evt.cs_rise));
endmodule

// File: tb/spi_cmd_port_test.sv
module spi_cmd_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        dout, dout_oe, cmd_valid;
  logic [15:0] cmd_word;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  int exp_strobes = 0;
  int settle = 0;
  int mode = 0;
  bit done = 1'b0;
  logic [15:0] exp_word = 16'h0000;
  bit q[$];

  always #5 clk = ~clk;

  spi_cmd_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .cmd_word(cmd_word), .cmd_valid(cmd_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cmd_valid) strobes++;
      chk(dout_oe == !cs_n, "R8 dout_oe", {31'd0, dout_oe}, {31'd0, !cs_n});
      if (settle > 0) settle--;
      else chk(cmd_word == exp_word, "R6 cmd_word hold", {16'd0, cmd_word}, {16'd0, exp_word});
    end
  end

  task automatic hc();
    repeat (5) @(negedge clk);
  endtask

  task automatic start(input int m);
    mode = m;
    sclk = (m != 0);
    hc();
    cs_n = 1'b0;
    q.delete();
    hc();
  endtask

  task automatic send_bit(input bit b);
    logic expd;
    sclk = 1'b0;
    din  = b;
    hc();
    expd = (q.size() >= 16) ? q[q.size()-16] : 1'b0;
    chk(dout == expd, "R7 dout daisy", {31'd0, dout}, {31'd0, expd});
    sclk = 1'b1;
    q.push_back(b);
    hc();
  endtask

  task automatic send_bits(input int n, input logic [31:0] val);
    for (int i = n - 1; i >= 0; i--) send_bit(val[i]);
  endtask

  task automatic finish(input bit to_idle, input string req);
    int n;
    bit ok;
    if (to_idle && mode == 0 && sclk) begin
      sclk = 1'b0;
      hc();
    end
    n  = q.size();
    ok = (n > 0) && (n % 16 == 0) && (sclk == (mode != 0));
    if (ok) begin
      for (int i = 0; i < 16; i++) exp_word[15-i] = q[n-16+i];
      exp_strobes++;
    end
    settle = 8;
    cs_n = 1'b1;
    hc();
    hc();
    chk(strobes == exp_strobes, req, strobes, exp_strobes);
    chk(cmd_word == exp_word, req, {16'd0, cmd_word}, {16'd0, exp_word});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cmd_word == 16'h0, "R9 reset word", {16'd0, cmd_word}, 32'd0);
    chk(cmd_valid == 1'b0, "R9 reset strobe", {31'd0, cmd_valid}, 32'd0);
    chk(dout == 1'b0, "R9 reset dout", {31'd0, dout}, 32'd0);
    rst_n = 1'b1;
    hc();
    // R1 idle-low clock, single word
    start(0); send_bits(16, 32'hA53C); finish(1'b1, "R1 mode0 word");
    // R2 idle-high clock
    start(1); send_bits(16, 32'h1234); finish(1'b1, "R2 mode1 word");
    // R3 short and long windows are dropped
    start(0); send_bits(15, 32'h7FFF); finish(1'b1, "R3 15 clocks");
    start(1); send_bits(17, 32'h1FFFF); finish(1'b1, "R3 17 clocks");
    start(0); finish(1'b1, "R3 zero clocks");
    // R10 a frame after a dropped window stands alone
    start(0); send_bits(16, 32'hC0DE); finish(1'b1, "R10 restart");
    // R4 double frame, last 16 bits win; dout replays the first half
    start(0); send_bits(32, 32'hBEEF_5AA5); finish(1'b1, "R4 32 clocks");
    start(1); send_bits(32, 32'h0F0F_F00F); finish(1'b1, "R4 mode1 32 clocks");
    // R5 clock not back at idle level
    start(0); send_bits(16, 32'h9999); finish(1'b0, "R5 idle mismatch");
    // R2 extreme patterns
    start(1); send_bits(16, 32'hFFFF); finish(1'b1, "R2 all ones");
    start(0); send_bits(16, 32'h0000); finish(1'b1, "R2 all zeros");
    start(1); send_bits(48, 32'h0001_8001); finish(1'b1, "R4 48 clocks");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule